// File: doc/BRIEF.md
# Multi-Format Pixel Unpacker with Colour Palette

This block sits between a frame-buffer fetch engine and a display timing generator. It takes 32-bit memory words through a valid/ready handshake and turns them into one 24-bit RGB888 pixel per advance strobe. A two-bit format code picks how each word is read. In 8-bit mode each byte is an index into a 256-entry colour palette. In 16-bit mode each half-word is a 5-6-5 colour that is widened to 8-8-8. In direct mode each word is one 8-8-8 colour, and its top byte is dropped.

A small two-state machine controls word intake. In `ST_EMPTY` no word is held, and `word_ready` is high whenever the format code is not zero. On an accepted word the transition `T_LOAD` moves it to `ST_FULL`. In `ST_FULL`, each advance strobe emits the next sub-word, most significant first. When the last sub-word is emitted, one of two transitions follows. `T_DRAIN` returns to `ST_EMPTY` if no word is offered. `T_CHAIN` stays in `ST_FULL` if a new word is accepted in the same cycle. Without a strobe, `T_WAIT` keeps the held word and its position.

The palette is written with one packed word. The palette read takes one cycle, and the direct formats are registered to match, so every mode has the same latency.

Top module: `pix_unpack_top`

## Requirements
- R1: After reset `pix_valid` is 0, no word is held, and `word_ready` equals (`fmt_sel` != 0).
- R2: Format code 0 means off. `word_ready` stays 0 and an offered word is not taken, so a later advance yields no pixel.
- R3: The format code is captured when a word is accepted. A word gives 4 pixels in code 1, 2 in code 2 and 1 in code 3, with the most significant sub-word first.
- R4: Code 1 (8 bits per pixel): each byte indexes the palette, and the pixel is that entry's 24-bit colour.
- R5: Code 2 (16 bits per pixel): a half-word holds red in 15:11, green in 10:5 and blue in 4:0. Each channel is widened to 8 bits by copying its top bits into its low bits.
- R6: Code 3 (direct): the pixel is word bits 23:0, with red in 23:16, green in 15:8 and blue in 7:0. Bits 31:24 have no effect.
- R7: `pix_valid` is 1 in exactly the cycle after an advance strobe that arrives while a word is held. A strobe with no word held gives no pixel.
- R8: A palette write takes the entry index from bits 31:24 and the red, green and blue bytes from 23:16, 15:8 and 7:0.
- R9: A palette read and a write to the same entry in the same cycle return the old colour. The following read returns the new one.
- R10: A new word can be accepted in the cycle its predecessor's last pixel is emitted (`word_ready` is 1 then), so pixels continue with no gap.
- R11: While no advance strobe arrives, the held word and its position are kept. No pixel is produced, and the next strobe resumes with the next sub-word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Format code: 0 off, 1 indexed 8-bit, 2 16-bit 5-6-5, 3 direct |
| word_valid | input | 1 | Fetched word offered |
| word_data | input | 32 | Fetched frame-buffer word |
| word_ready | output | 1 | Word taken this cycle when valid |
| pix_adv | input | 1 | Pixel-advance strobe from the timing side |
| pal_we | input | 1 | Palette write enable |
| pal_wdata | input | 32 | Packed palette write: index, red, green, blue |
| pix_valid | output | 1 | Pixel output valid |
| pix_rgb | output | 24 | Pixel colour, red in 23:16, green 15:8, blue 7:0 |

## Verification
The bench builds the block with the default of 256 palette entries. This lets it fill every entry with a distinct colour and reach both the lowest and highest indices in one word. At this size the read-during-write collision can be set up on a mid-table entry while the other entries stay intact. The timing is such that a chained word, a paused word, and a format change between acceptance and emission all arise within a few cycles of each other.

// File: rtl/pix_pkg.sv
package pix_pkg;

    localparam int WORD_W = 32;
    localparam int RGB_W  = 24;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_IDX8   = 2'd1,
        MODE_RGB565 = 2'd2,
        MODE_DIRECT = 2'd3
    } pix_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } word_state_e;

    // Index of the last sub-word in a word for a given mode
    function automatic logic [1:0] last_slot(pix_mode_e m);
        case (m)
            MODE_IDX8:   return 2'd3;
            MODE_RGB565: return 2'd1;
            default:     return 2'd0;
        endcase
    endfunction

    // Widen a 5-6-5 colour to 8-8-8 by repeating each channel's top bits
    function automatic logic [RGB_W-1:0] widen565(logic [15:0] h);
        return {h[15:11], h[15:13], h[10:5], h[10:9], h[4:0], h[4:2]};
    endfunction

endpackage

// File: rtl/pix_word_fsm.sv
module pix_word_fsm
    import pix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic              pix_adv,
    output logic              emit,
    output logic              full,
    output pix_mode_e         cur_mode,
    output logic [WORD_W-1:0] cur_word,
    output logic [1:0]        cur_slot
);

    word_state_e       state_q, state_d;
    pix_mode_e         mode_q;
    logic [WORD_W-1:0] word_q;
    logic [1:0]        slot_q;
    logic              at_last;
    logic              take;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next state and handshake outputs
    always_comb begin
        at_last    = (slot_q == last_slot(mode_q));
        word_ready = 1'b0;
        emit       = 1'b0;
        state_d    = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                word_ready = (fmt_sel != 2'd0);
                if (word_valid && word_ready) state_d = ST_FULL;     // T_LOAD
            end
            ST_FULL: begin
                emit = pix_adv;
                if (pix_adv && at_last) begin
                    word_ready = (fmt_sel != 2'd0);
                    state_d    = (word_valid && word_ready) ? ST_FULL  // T_CHAIN
                                                            : ST_EMPTY; // T_DRAIN
                end
                // otherwise T_WAIT or step to the next sub-word
            end
            default: state_d = ST_EMPTY;
        endcase
        take = word_valid && word_ready;
    end

    // Held word, captured mode and sub-word position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            mode_q <= MODE_OFF;
            slot_q <= '0;
        end else if (take) begin
            word_q <= word_data;
            mode_q <= pix_mode_e'(fmt_sel);
            slot_q <= '0;
        end else if (emit) begin
            slot_q <= slot_q + 2'd1;
        end
    end

    assign full     = (state_q == ST_FULL);
    assign cur_mode = mode_q;
    assign cur_word = word_q;
    assign cur_slot = slot_q;

    // R3: position never passes the last sub-word of the held mode
    a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |-> (slot_q <= last_slot(mode_q)));

    // R11: without a strobe the held word and position do not move
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !pix_adv) |=> ($stable(word_q) && $stable(slot_q)));

    // R2: an empty unpacker with the format off stays empty
    a_r2_off_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && fmt_sel == 2'd0) |=> (state_q == ST_EMPTY));

endmodule

// File: rtl/pix_palette.sv
module pix_palette
    import pix_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [RGB_W-1:0]  rd_rgb
);

    logic [RGB_W-1:0] mem [ENTRIES];
    logic [IDX_W-1:0] wr_idx;

    assign wr_idx = wdata[RGB_W +: IDX_W];

    // Write and read in the same process: a colliding read sees the old entry
    always_ff @(posedge clk) begin
        if (we)    mem[wr_idx] <= wdata[RGB_W-1:0];
        if (rd_en) rd_rgb      <= mem[rd_idx];
    end

endmodule

// File: rtl/pix_expand.sv
module pix_expand
    import pix_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  pix_mode_e         mode,
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        slot,
    output logic [IDX_W-1:0]  pal_idx,
    input  logic [RGB_W-1:0]  pal_rgb,
    output logic              pix_valid,
    output logic [RGB_W-1:0]  pix_rgb
);

    logic [WORD_W-1:0] shifted;
    logic [15:0]       half;
    logic [RGB_W-1:0]  direct_d;
    logic [RGB_W-1:0]  direct_q;
    pix_mode_e         mode_q;
    logic              valid_q;

    // Sub-word selection, most significant first
    always_comb begin
        shifted  = word >> {(2'd3 - slot), 3'b000};
        half     = slot[0] ? word[15:0] : word[31:16];
        pal_idx  = shifted[IDX_W-1:0];
        direct_d = (mode == MODE_RGB565) ? widen565(half) : word[RGB_W-1:0];
    end

    // Delay stage matching the palette read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            mode_q   <= MODE_OFF;
            direct_q <= '0;
        end else begin
            valid_q <= emit;
            if (emit) begin
                mode_q   <= mode;
                direct_q <= direct_d;
            end
        end
    end

    assign pix_valid = valid_q;
    assign pix_rgb   = (mode_q == MODE_IDX8) ? pal_rgb : direct_q;

endmodule

// File: rtl/pix_unpack_top.sv
module pix_unpack_top
    import pix_pkg::*;
#(
    parameter int PAL_ENTRIES = 256,
    localparam int IDX_W      = $clog2(PAL_ENTRIES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  fmt_sel,
    input  logic        word_valid,
    input  logic [31:0] word_data,
    output logic        word_ready,
    input  logic        pix_adv,
    input  logic        pal_we,
    input  logic [31:0] pal_wdata,
    output logic        pix_valid,
    output logic [23:0] pix_rgb
);

    logic              emit;
    logic              full;
    pix_mode_e         cur_mode;
    logic [WORD_W-1:0] cur_word;
    logic [1:0]        cur_slot;
    logic [IDX_W-1:0]  pal_idx;
    logic [RGB_W-1:0]  pal_rgb;

    pix_word_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_sel    (fmt_sel),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .pix_adv    (pix_adv),
        .emit       (emit),
        .full       (full),
        .cur_mode   (cur_mode),
        .cur_word   (cur_word),
        .cur_slot   (cur_slot)
    );

    pix_palette #(.ENTRIES(PAL_ENTRIES)) u_pal (
        .clk    (clk),
        .we     (pal_we),
        .wdata  (pal_wdata),
        .rd_en  (emit && cur_mode == MODE_IDX8),
        .rd_idx (pal_idx),
        .rd_rgb (pal_rgb)
    );

    pix_expand #(.IDX_W(IDX_W)) u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .mode      (cur_mode),
        .word      (cur_word),
        .slot      (cur_slot),
        .pal_idx   (pal_idx),
        .pal_rgb   (pal_rgb),
        .pix_valid (pix_valid),
        .pix_rgb   (pix_rgb)
    );

    // R7: a pixel appears only after a strobe that found a held word
    a_r7_valid_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ($past(pix_adv) && $past(full)));

    // R7: a strobe on a held word always yields a pixel next cycle
    a_r7_adv_gives_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_adv && full) |=> pix_valid);

endmodule

// File: tb/sim_pix_unpack_top.sv
module sim_pix_unpack_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        pix_adv = 1'b0;
    logic        pal_we = 1'b0;
    logic [31:0] pal_wdata = '0;
    logic        pix_valid;
    logic [23:0] pix_rgb;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_unpack_top u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .pix_adv(pix_adv), .pal_we(pal_we), .pal_wdata(pal_wdata),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb)
    );

    function automatic logic [23:0] pal_model(logic [7:0] i);
        return {i ^ 8'h5A, i + 8'd3, ~i};
    endfunction

    function automatic logic [23:0] exp565(logic [15:0] h);
        logic [4:0] r = h[15:11];
        logic [5:0] g = h[10:5];
        logic [4:0] b = h[4:0];
        return {r, r[4:2], g, g[5:4], b, b[4:2]};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_pix(string req, logic [23:0] exp);
        chk(req, {31'd0, pix_valid}, 32'd1);
        chk(req, {8'd0, pix_rgb}, {8'd0, exp});
    endtask

    task automatic load_word(logic [1:0] f, logic [31:0] w);
        fmt_sel = f; word_valid = 1'b1; word_data = w;
        #1 chk("R1 ready when empty", {31'd0, word_ready}, 32'd1);
        tick();
        word_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; fmt_sel = 2'd0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 valid after reset", {31'd0, pix_valid}, 32'd0);
        chk("R1 ready fmt off", {31'd0, word_ready}, 32'd0);
        fmt_sel = 2'd1; #1;
        chk("R1 ready fmt on", {31'd0, word_ready}, 32'd1);
    endtask

    task automatic t_fill_palette();
        for (int i = 0; i < 256; i++) begin
            pal_we = 1'b1; pal_wdata = {i[7:0], pal_model(i[7:0])};
            tick();
        end
        pal_we = 1'b0;
    endtask

    task automatic t_indexed();
        logic [31:0] w = 32'hFF00_807F;
        load_word(2'd1, w);
        pix_adv = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            expect_pix("R4 R8 R3 indexed byte", pal_model(w[31-8*k -: 8]));
        end
        pix_adv = 1'b0;
        tick();
        chk("R3 four pixels per word", {31'd0, pix_valid}, 32'd0);
    endtask

    task automatic t_rgb565();
        logic [31:0] w = {16'b10110_101101_01101, 16'b00001_110010_11111};
        load_word(2'd2, w);
        fmt_sel = 2'd3;   // changed after capture: must not matter
        pix_adv = 1'b1;
        tick(); expect_pix("R5 R3 first half", exp565(w[31:16]));
        tick(); expect_pix("R5 R3 second half", exp565(w[15:0]));
        pix_adv = 1'b0;
        tick();
        chk("R3 two pixels per word", {31'd0, pix_valid}, 32'd0);
    endtask

    task automatic t_direct();
        load_word(2'd3, 32'hDEAD_BEEF);
        pix_adv = 1'b1;
        tick(); expect_pix("R6 direct top ignored", 24'hADBEEF);
        tick();
        chk("R7 no word no pixel", {31'd0, pix_valid}, 32'd0);
        pix_adv = 1'b0;
        tick();
    endtask

    task automatic t_off();
        fmt_sel = 2'd0; word_valid = 1'b1; word_data = 32'h0012_3456;
        #1 chk("R2 ready low when off", {31'd0, word_ready}, 32'd0);
        tick();
        word_valid = 1'b0; fmt_sel = 2'd3; pix_adv = 1'b1;
        tick();
        chk("R2 off word not taken", {31'd0, pix_valid}, 32'd0);
        pix_adv = 1'b0;
        tick();
    endtask

    task automatic t_chain();
        load_word(2'd3, 32'h0011_2233);
        pix_adv = 1'b1; word_valid = 1'b1; word_data = 32'hFF44_5566;
        #1 chk("R10 ready on last emit", {31'd0, word_ready}, 32'd1);
        tick();
        expect_pix("R10 first of chain", 24'h112233);
        word_valid = 1'b0;
        tick();
        expect_pix("R10 chained word no gap", 24'h445566);
        pix_adv = 1'b0;
        tick();
    endtask

    task automatic t_pause();
        logic [31:0] w = 32'h0102_0304;
        load_word(2'd1, w);
        pix_adv = 1'b1;
        tick(); expect_pix("R11 before pause", pal_model(8'h01));
        pix_adv = 1'b0;
        tick();
        chk("R11 paused no pixel", {31'd0, pix_valid}, 32'd0);
        tick();
        chk("R11 paused no pixel", {31'd0, pix_valid}, 32'd0);
        pix_adv = 1'b1;
        tick(); expect_pix("R11 resume slot", pal_model(8'h02));
        tick(); expect_pix("R11 resume slot", pal_model(8'h03));
        tick(); expect_pix("R11 resume slot", pal_model(8'h04));
        pix_adv = 1'b0;
        tick();
    endtask

    task automatic t_collision();
        load_word(2'd1, 32'h4040_4040);
        pix_adv = 1'b1; pal_we = 1'b1; pal_wdata = 32'h4012_3456;
        tick();
        expect_pix("R9 collision old value", pal_model(8'h40));
        pal_we = 1'b0;
        tick();
        expect_pix("R9 new value after", 24'h123456);
        tick(); tick();
        pix_adv = 1'b0;
        tick();
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fill_palette();
        t_indexed();
        t_rgb565();
        t_direct();
        t_off();
        t_chain();
        t_pause();
        t_collision();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule